// File: doc/BRIEF.md
# Double-Width Funnel Right Shifter

This block shifts a destination word toward bit 0 by a variable count and fills the vacated upper positions from the low end of a second source word. Together the two words act as one double-width funnel. It also produces the carry, overflow, sign, zero and parity status that a processor's arithmetic unit would report for such an operation. It is meant to sit in an execution datapath: the operands come from a register file, and the flag outputs, together with a flag write enable, go back to the flags register.

The operand size is 16, 32 or 64 bits. The raw 8-bit count is masked to 5 bits, or to 6 bits for a 64-bit operation in the wide execution mode. A masked count of zero leaves the destination and all flags untouched. A 16-bit operation with a count between 17 and 31 has no architectural meaning. In that case the block drives a fixed, repeatable value and raises an indicator so that the consumer can tell. By default the outputs are registered, which gives one cycle of latency. A parameter makes the block purely combinational.

Top module: `funnel_rshift`

## Requirements
- R1: The effective count is cnt_raw_i[5:0] when the size is 64 bits and wide_mode_i is 1. In every other case it is cnt_raw_i[4:0]. Bits above the mask are ignored.
- R2: The size select encodes the operand width: 0 gives 16 bits, 1 gives 32 bits, and 2 or 3 give 64 bits. For an effective count c with 1 ≤ c ≤ n, where n is the width, result bit i equals dst bit i+c when i+c < n and src bit i+c−n otherwise.
- R3: When the effective count is 0, res_o equals the destination at the selected width and flags_we_o is 0. Every flag output equals its matching flag input.
- R4: When the effective count c is nonzero, cf_o equals bit c−1 of the concatenation {src,dst} at width n. For c ≤ n this is dst bit c−1.
- R5: When the effective count is 1, of_o is 1 exactly when the result's sign bit differs from the sign bit of the original destination.
- R6: When the effective count is 2 or more, of_o is 0.
- R7: When the effective count is nonzero, sf_o is the top bit of the result at the selected width and zf_o is 1 when that result is zero. pf_o is 1 when res_o[7:0] holds an even number of ones. flags_we_o is 1.
- R8: For the 16-bit and 32-bit sizes, res_o bits at and above the operand width are 0.
- R9: For a 16-bit size with an effective count of 17 to 31, undef_o is 1. Result bit i is then bit (i+c) mod 32 of {src[15:0],dst[15:0]}, and cf_o is bit c−1 of that concatenation. In every other case undef_o is 0.
- R10: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| dst_i | input | 64 | Word being shifted |
| src_i | input | 64 | Word supplying the bits shifted in |
| size_sel_i | input | 2 | Operand width: 0=16, 1=32, 2/3=64 |
| cnt_raw_i | input | 8 | Unmasked shift count |
| wide_mode_i | input | 1 | Enables the 6-bit count mask for 64-bit operations |
| cf_i | input | 1 | Previous carry flag |
| of_i | input | 1 | Previous overflow flag |
| sf_i | input | 1 | Previous sign flag |
| zf_i | input | 1 | Previous zero flag |
| pf_i | input | 1 | Previous parity flag |
| res_o | output | 64 | Shift result, zero above the operand width |
| cf_o | output | 1 | Carry: last bit shifted out |
| of_o | output | 1 | Overflow: sign change on a one-bit shift |
| sf_o | output | 1 | Sign of the result |
| zf_o | output | 1 | Result is zero |
| pf_o | output | 1 | Even parity of the low result byte |
| flags_we_o | output | 1 | Flags are updated (effective count nonzero) |
| undef_o | output | 1 | Count exceeds the operand width |

## Verification
With the default registered outputs, every result and flag is due exactly one rising edge after the inputs that produce it. The bench therefore drives each operand set on a falling edge and samples on the next falling edge, once the register has captured that set and before new stimulus arrives. Expected values come from a bit-by-bit loop model that walks the concatenation, including the modulo wrap of the undefined 16-bit case. All three sizes are swept over raw counts 0 to 63 with random operands. A reset-time check confirms that the outputs are zero while reset is held.

// File: rtl/funnel_rshift.sv
module funnel_rshift #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] dst_i,
  input  logic [63:0] src_i,
  input  logic [1:0]  size_sel_i,
  input  logic [7:0]  cnt_raw_i,
  input  logic        wide_mode_i,
  input  logic        cf_i,
  input  logic        of_i,
  input  logic        sf_i,
  input  logic        zf_i,
  input  logic        pf_i,
  output logic [63:0] res_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        sf_o,
  output logic        zf_o,
  output logic        pf_o,
  output logic        flags_we_o,
  output logic        undef_o
);
  localparam int DW = 64;
  localparam int CW = 2 * DW;
  localparam int IW = $clog2(CW);

  logic          is64, is32;
  logic [7:0]    cnt_m;
  logic [5:0]    cnt;
  logic          cnt_zero;
  logic [7:0]    nbits;
  logic [CW-1:0] cat;
  logic [DW-1:0] size_mask, shifted, res_c;
  logic [IW-1:0] last_idx;
  logic          sgn_res, sgn_dst;
  logic          cf_c, of_c, sf_c, zf_c, pf_c, we_c, ud_c;

  assign is64  = size_sel_i[1];
  assign is32  = (size_sel_i == 2'b01);
  assign nbits = is64 ? 8'd64 : (is32 ? 8'd32 : 8'd16);

  assign cnt_m    = cnt_raw_i & ((is64 && wide_mode_i) ? 8'h3F : 8'h1F);
  assign cnt      = cnt_m[5:0];
  assign cnt_zero = (cnt_m == 8'd0);

  always_comb begin
    if (is64)      cat = {src_i, dst_i};
    else if (is32) cat = {64'd0, src_i[31:0], dst_i[31:0]};
    else           cat = {64'd0, src_i[15:0], dst_i[15:0], src_i[15:0], dst_i[15:0]};
  end

  assign size_mask = is64 ? {DW{1'b1}} : (is32 ? {32'd0, {32{1'b1}}} : {48'd0, {16{1'b1}}});

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      shifted[i] = cat[IW'(i) + IW'(cnt)];
    end
  end

  assign res_c    = (cnt_zero ? dst_i : shifted) & size_mask;
  assign last_idx = IW'(cnt) - IW'(1);

  always_comb begin
    if (is64) begin
      sgn_res = res_c[63];
      sgn_dst = dst_i[63];
    end else if (is32) begin
      sgn_res = res_c[31];
      sgn_dst = dst_i[31];
    end else begin
      sgn_res = res_c[15];
      sgn_dst = dst_i[15];
    end
  end

  assign we_c = !cnt_zero;
  assign ud_c = (cnt_m > nbits);
  assign cf_c = cnt_zero ? cf_i : cat[last_idx];
  assign of_c = cnt_zero ? of_i : ((cnt == 6'd1) ? (sgn_res ^ sgn_dst) : 1'b0);
  assign sf_c = cnt_zero ? sf_i : sgn_res;
  assign zf_c = cnt_zero ? zf_i : (res_c == '0);
  assign pf_c = cnt_zero ? pf_i : ~^res_c[7:0];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_o      <= '0;
          cf_o       <= 1'b0;
          of_o       <= 1'b0;
          sf_o       <= 1'b0;
          zf_o       <= 1'b0;
          pf_o       <= 1'b0;
          flags_we_o <= 1'b0;
          undef_o    <= 1'b0;
        end else begin
          res_o      <= res_c;
          cf_o       <= cf_c;
          of_o       <= of_c;
          sf_o       <= sf_c;
          zf_o       <= zf_c;
          pf_o       <= pf_c;
          flags_we_o <= we_c;
          undef_o    <= ud_c;
        end
      end
    end else begin : g_comb
      assign res_o      = res_c;
      assign cf_o       = cf_c;
      assign of_o       = of_c;
      assign sf_o       = sf_c;
      assign zf_o       = zf_c;
      assign pf_o       = pf_c;
      assign flags_we_o = we_c;
      assign undef_o    = ud_c;
    end
  endgenerate
endmodule

// File: rtl/funnel_rshift_chk.sv
module funnel_rshift_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] dst_i,
  input logic [1:0]  size_sel_i,
  input logic [5:0]  cnt_lo,
  input logic        wide_mode_i,
  input logic [4:0]  flags_in,
  input logic [63:0] res_o,
  input logic [4:0]  flags_out,
  input logic        flags_we_o,
  input logic        undef_o
);
  logic [63:0] d_dst;
  logic [1:0]  d_size;
  logic [5:0]  d_cnt;
  logic        d_wide;
  logic [4:0]  d_flags;
  logic        ok;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_dst <= '0; d_size <= '0; d_cnt <= '0; d_wide <= 1'b0; d_flags <= '0; ok <= 1'b0;
        end else begin
          d_dst <= dst_i; d_size <= size_sel_i; d_cnt <= cnt_lo; d_wide <= wide_mode_i;
          d_flags <= flags_in; ok <= 1'b1;
        end
      end
    end else begin : g_pass
      assign d_dst = dst_i;
      assign d_size = size_sel_i;
      assign d_cnt = cnt_lo;
      assign d_wide = wide_mode_i;
      assign d_flags = flags_in;
      assign ok = 1'b1;
    end
  endgenerate

  logic        d_w64, d_zero, d_one;
  logic [63:0] d_dst_sz;
  assign d_w64    = d_size[1] && d_wide;
  assign d_zero   = d_w64 ? (d_cnt == 6'd0) : (d_cnt[4:0] == 5'd0);
  assign d_one    = d_w64 ? (d_cnt == 6'd1) : (d_cnt[4:0] == 5'd1);
  assign d_dst_sz = d_size[1] ? d_dst : (d_size[0] ? {32'd0, d_dst[31:0]} : {48'd0, d_dst[15:0]});

  a_r1_we_tracks_mask: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    flags_we_o == !d_zero);
  a_r3_hold_on_zero: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    !flags_we_o |-> (flags_out == d_flags && res_o == d_dst_sz));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    (flags_we_o && flags_out[3]) |-> d_one);
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    flags_we_o |-> (flags_out[1] == (res_o == 64'd0)));
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    (!d_size[1]) |-> (res_o[63:32] == 32'd0 && (d_size[0] || res_o[31:16] == 16'd0)));
  a_r9_undef_16only: assert property (@(posedge clk) disable iff (!rst_n || !ok)
    undef_o == (d_size == 2'd0 && d_cnt[4:0] > 5'd16));
endmodule

bind funnel_rshift funnel_rshift_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .dst_i(dst_i), .size_sel_i(size_sel_i),
  .cnt_lo(cnt_raw_i[5:0]), .wide_mode_i(wide_mode_i),
  .flags_in({cf_i, of_i, sf_i, zf_i, pf_i}), .res_o(res_o),
  .flags_out({cf_o, of_o, sf_o, zf_o, pf_o}), .flags_we_o(flags_we_o), .undef_o(undef_o)
);

// File: tb/funnel_rshift_tb.sv
module funnel_rshift_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] dst, src;
  logic [1:0]  sz;
  logic [7:0]  raw;
  logic        wide;
  logic [4:0]  fin;
  logic [63:0] res;
  logic        cf, of, sf, zf, pf, we, ud;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  funnel_rshift #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .dst_i(dst), .src_i(src), .size_sel_i(sz),
    .cnt_raw_i(raw), .wide_mode_i(wide), .cf_i(fin[4]), .of_i(fin[3]),
    .sf_i(fin[2]), .zf_i(fin[1]), .pf_i(fin[0]), .res_o(res), .cf_o(cf),
    .of_o(of), .sf_o(sf), .zf_o(zf), .pf_o(pf), .flags_we_o(we), .undef_o(ud)
  );

  task automatic ref_calc(input logic [63:0] d, input logic [63:0] s, input logic [1:0] z,
                          input logic [7:0] r, input logic w, input logic [4:0] fi,
                          output logic [63:0] er, output logic [4:0] ef,
                          output logic ewe, output logic eud);
    int n, c, j, k;
    n = (z == 2'd0) ? 16 : (z == 2'd1) ? 32 : 64;
    c = (z[1] && w) ? int'(r & 8'h3F) : int'(r & 8'h1F);
    er = '0;
    if (c == 0) begin
      for (int i = 0; i < n; i++) er[i] = d[i];
      ef = fi; ewe = 1'b0; eud = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        j = (i + c) % (2 * n);
        er[i] = (j < n) ? d[j] : s[j - n];
      end
      k = (c - 1) % (2 * n);
      ef[4] = (k < n) ? d[k] : s[k - n];
      ef[3] = (c == 1) ? (er[n-1] ^ d[n-1]) : 1'b0;
      ef[2] = er[n-1];
      ef[1] = (er == 64'd0);
      ef[0] = ~^er[7:0];
      ewe = 1'b1;
      eud = (c > n);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] d, input logic [63:0] s,
                     input logic [1:0] z, input logic [7:0] r, input logic w, input logic [4:0] fi);
    logic [63:0] er; logic [4:0] ef; logic ewe, eud;
    @(negedge clk);
    dst = d; src = s; sz = z; raw = r; wide = w; fin = fi;
    ref_calc(d, s, z, r, w, fi, er, ef, ewe, eud);
    @(negedge clk);
    checks++;
    if (res !== er || {cf, of, sf, zf, pf} !== ef || we !== ewe || ud !== eud) begin
      failures++;
      $display("FAIL %s size=%0d cnt=%0d: res=%h flags=%b we=%b ud=%b expected res=%h flags=%b we=%b ud=%b",
               tag, z, r, res, {cf, of, sf, zf, pf}, we, ud, er, ef, ewe, eud);
    end
  endtask

  task automatic t_reset();
    dst = 64'hFFFF_FFFF_FFFF_FFFF; src = '1; sz = 2'd2; raw = 8'd5; wide = 1'b1; fin = 5'b11111;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 64'd0 || {cf, of, sf, zf, pf, we, ud} !== 7'd0) begin
      failures++;
      $display("FAIL R10 reset: res=%h bits=%b expected 0", res, {cf, of, sf, zf, pf, we, ud});
    end
    rst_n = 1'b1;
  endtask

  task automatic t_mask();
    run("R1 mask5 32b raw=0x41", 64'h0000_0000_8000_0003, 64'h1, 2'd1, 8'h41, 1'b1, 5'b0);
    run("R1 mask6 64b raw=0xE1", 64'h8000_0000_0000_0005, 64'h3, 2'd2, 8'hE1, 1'b1, 5'b0);
    run("R1 64b legacy raw=0x21", 64'h8000_0000_0000_0005, 64'h3, 2'd2, 8'h21, 1'b0, 5'b0);
    run("R1 raw=0x40 legacy 64b is zero", 64'h1234, 64'h5678, 2'd3, 8'h40, 1'b0, 5'b10101);
  endtask

  task automatic t_zero();
    run("R3 zero count 16b", 64'hDEAD_BEEF_CAFE_F00D, 64'h1, 2'd0, 8'h20, 1'b1, 5'b11011);
    run("R3 zero count 64b", 64'hDEAD_BEEF_CAFE_F00D, 64'h1, 2'd2, 8'h00, 1'b1, 5'b00100);
  endtask

  task automatic t_sizes();
    run("R2 R8 16b funnel", 64'hFFFF_FFFF_FFFF_8001, 64'hAAAA_AAAA_AAAA_00F3, 2'd0, 8'd4, 1'b0, 5'b0);
    run("R2 R8 32b funnel", 64'hFFFF_FFFF_1234_5678, 64'h0000_0000_0000_00AB, 2'd1, 8'd8, 1'b0, 5'b0);
    run("R2 64b funnel full", 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 2'd2, 8'd63, 1'b1, 5'b0);
    run("R2 R4 16b count=16", 64'h8001, 64'h5A5A, 2'd0, 8'd16, 1'b0, 5'b0);
  endtask

  task automatic t_overflow();
    run("R5 R4 sign change", 64'h0000_0000_0000_4001, 64'h1, 2'd0, 8'd1, 1'b0, 5'b0);
    run("R5 no sign change", 64'h8000_0000_0000_0000, 64'h1, 2'd2, 8'd1, 1'b1, 5'b11111);
    run("R6 multi-bit count", 64'h0000_0000_4000_0000, 64'hFFFF_FFFF, 2'd1, 8'd3, 1'b0, 5'b01000);
  endtask

  task automatic t_flags();
    run("R7 zero result parity", 64'h0000_0000_0000_000F, 64'h0, 2'd2, 8'd4, 1'b1, 5'b0);
    run("R7 odd parity", 64'h0000_0000_0000_0700, 64'h0, 2'd1, 8'd8, 1'b0, 5'b11111);
  endtask

  task automatic t_undef();
    run("R9 16b count=17", 64'h0000_0000_0000_ABCD, 64'h0000_0000_0000_1357, 2'd0, 8'd17, 1'b0, 5'b0);
    run("R9 16b count=31", 64'h0000_0000_0000_8421, 64'h0000_0000_0000_F00F, 2'd0, 8'd31, 1'b1, 5'b0);
  endtask

  task automatic t_sweep();
    for (int z = 0; z < 3; z++)
      for (int c = 0; c < 64; c++)
        for (int k = 0; k < 2; k++)
          run("R2 R4 R7 R9 sweep", {$urandom, $urandom}, {$urandom, $urandom}, 2'(z), 8'(c),
              1'(k), 5'($urandom));
  endtask

  initial begin
    t_reset();
    t_mask();
    t_zero();
    t_sizes();
    t_overflow();
    t_flags();
    t_undef();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule